// File: doc/BRIEF.md
# Gated Multi-Cycle Period Counter

This block measures the period of a squared-up oscillator signal. It counts ticks of a fast reference over a programmable number of input cycles. The fast reference is a 2 MHz enable strobe, made inside the block by dividing the system clock. The oscillator input is asynchronous. It passes through a synchronizer and a falling-edge detector.

A controller runs each measurement in four steps:
1. It loads the cycle count N and raises the gate enable.
2. It pulses `prime`. This sets the input conditioning flip-flop and readies the cycle counter, standing in for the one dummy edge a ripple counter needs before it counts accurately.
3. It pulses `ff_clear`. This lets real oscillator edges through.
4. The first real falling edge starts the total-time counter. The Nth falling edge after it stops the counter.

The total then holds the number of reference ticks spanning N input periods. Doubling N for each octave up keeps the same reference total across octaves, which suits an octave-by-octave tuning loop.

Top module: `period_gauge`

## Requirements
- R1: After reset, `total` is 0 and `busy`, `done`, `ovf`, `ff_state` and `cyc_active` are all 0.
- R2: A `prime` pulse while `gate_en` is high and the block is not busy does three things: it sets `ff_state`, raises `busy` and clears `total` and `ovf`. A later `ff_clear` pulse clears `ff_state`.
- R3: Falling input edges that arrive while `ff_state` is high are ignored. They neither start timing nor count as cycles.
- R4: After `ff_clear`, the first falling edge of `osc_in` raises `cyc_active`. `total` then counts reference strobes (one every DIV system clocks) only while `cyc_active` is high. With the period a multiple of DIV clocks, the final `total` equals N·period/DIV.
- R5: Measuring with N=1, 2 and 4 at periods P, P/2 and P/4 gives the same total.
- R6: A programmed N of 0 is measured as N=1.
- R7: `done` is a single-cycle pulse at the stop. Afterwards `total` stays fixed, and further input edges are ignored, until the next accepted `prime`.
- R8: `total` saturates at all-ones instead of wrapping. An increment attempted at all-ones sets `ovf`, which holds until the next accepted `prime`.
- R9: Dropping `gate_en` at any time returns the block to idle. It clears `busy`, `cyc_active` and `ff_state`, and `done` is never pulsed for that measurement.
- R10: A `prime` pulse while `gate_en` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_in | input | 1 | Asynchronous squared-up oscillator signal |
| gate_en | input | 1 | Enables the measurement; low aborts it |
| prime | input | 1 | Preset pulse that starts and primes a measurement |
| ff_clear | input | 1 | Clears the conditioning flip-flop to pass real edges |
| cycles_n | input | CYC_W | Number of input cycles to time (0 means 1) |
| total | output | TOTAL_W | Reference ticks counted over N cycles |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle pulse when the count stops |
| ovf | output | 1 | Total saturated during this measurement |
| ff_state | output | 1 | State of the conditioning flip-flop |
| cyc_active | output | 1 | Cycle counter is timing (total counter enabled) |

## Verification
The bench puts oscillator edges into the primed window. A design that let these edges through would start early and report a long total. It sweeps N against octave-scaled periods, where an off-by-one in the edge count would make the three totals disagree. It uses N=0, which a naive compare would turn into 2^CYC_W cycles or a hang. An overlong run checks that the count saturates, where a wrapping counter would report a small total. After the stop, extra edges check that `total` holds. A gate drop mid-run must produce no `done`.

// File: rtl/pg_pkg.sv
package pg_pkg;
   typedef enum logic [2:0] {
      PG_IDLE   = 3'd0,
      PG_PRIMED = 3'd1,
      PG_ARMED  = 3'd2,
      PG_RUN    = 3'd3,
      PG_DONE   = 3'd4
   } pg_state_e;
endpackage

// File: rtl/pg_sync_edge.sv
module pg_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic fall
);
   localparam int DEPTH = STAGES + 1;

   logic [DEPTH-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q[0] <= 1'b0;
      else        sh_q[0] <= async_in;
   end

   for (genvar g = 1; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q[g] <= 1'b0;
         else        sh_q[g] <= sh_q[g-1];
      end
   end

   assign fall = sh_q[DEPTH-1] & ~sh_q[DEPTH-2];
endmodule

// File: rtl/pg_tick_gen.sv
module pg_tick_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (DIV == 1) begin : g_pass
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign tick = 1'b1;
   end else begin : g_div
      localparam int W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             cnt_q <= '0;
         else if (cnt_q == LAST) cnt_q <= '0;
         else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == LAST);
   end
endmodule

// File: rtl/pg_cycle_ctrl.sv
module pg_cycle_ctrl
   import pg_pkg::*;
#(
   parameter int CYC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate_en,
   input  logic             prime,
   input  logic             ff_clear,
   input  logic             fall,
   input  logic [CYC_W-1:0] cycles_n,
   output logic             start_clr,
   output logic             run,
   output logic             busy,
   output logic             done,
   output logic             ff_q
);
   pg_state_e        state_q, state_d;
   logic [CYC_W-1:0] cnt_q, n_lat_q, n_eff;
   logic             last_edge;
   logic             done_q;

   assign n_eff     = (n_lat_q == '0) ? CYC_W'(1) : n_lat_q;
   assign last_edge = (cnt_q + CYC_W'(1)) == n_eff;
   assign start_clr = gate_en && prime &&
                      (state_q == PG_IDLE || state_q == PG_DONE);

   always_comb begin
      state_d = state_q;
      if (!gate_en) begin
         state_d = PG_IDLE;
      end else begin
         unique case (state_q)
            PG_IDLE, PG_DONE: if (prime)    state_d = PG_PRIMED;
            PG_PRIMED:        if (ff_clear) state_d = PG_ARMED;
            PG_ARMED:         if (fall)     state_d = PG_RUN;
            PG_RUN:           if (fall && last_edge) state_d = PG_DONE;
            default:          state_d = PG_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PG_IDLE;
         cnt_q   <= '0;
         n_lat_q <= '0;
         done_q  <= 1'b0;
         ff_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= gate_en && (state_q == PG_RUN) && fall && last_edge;
         if (start_clr) n_lat_q <= cycles_n;
         if (state_q == PG_ARMED && fall)    cnt_q <= '0;
         else if (state_q == PG_RUN && fall) cnt_q <= cnt_q + CYC_W'(1);
         if (!gate_en)       ff_q <= 1'b0;
         else if (start_clr) ff_q <= 1'b1;
         else if (ff_clear)  ff_q <= 1'b0;
      end
   end

   assign run  = (state_q == PG_RUN);
   assign busy = (state_q == PG_PRIMED) || (state_q == PG_ARMED) ||
                 (state_q == PG_RUN);
   assign done = done_q;
endmodule

// File: rtl/pg_total_ctr.sv
module pg_total_ctr #(
   parameter int TOTAL_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               inc,
   output logic [TOTAL_W-1:0] total,
   output logic               ovf
);
   localparam logic [TOTAL_W-1:0] FULL = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         total <= '0;
         ovf   <= 1'b0;
      end else if (clr) begin
         total <= '0;
         ovf   <= 1'b0;
      end else if (inc) begin
         if (total == FULL) ovf   <= 1'b1;
         else               total <= total + 1'b1;
      end
   end
endmodule

// File: rtl/period_gauge.sv
module period_gauge #(
   parameter int TOTAL_W     = 16,
   parameter int CYC_W       = 8,
   parameter int TICK_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               osc_in,
   input  logic               gate_en,
   input  logic               prime,
   input  logic               ff_clear,
   input  logic [CYC_W-1:0]   cycles_n,
   output logic [TOTAL_W-1:0] total,
   output logic               busy,
   output logic               done,
   output logic               ovf,
   output logic               ff_state,
   output logic               cyc_active
);
   if (TOTAL_W < 2)     $error("TOTAL_W must be at least 2");
   if (CYC_W < 1)       $error("CYC_W must be at least 1");
   if (TICK_DIV < 1)    $error("TICK_DIV must be at least 1");
   if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");

   logic fall, tick, start_clr, run;

   pg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(osc_in), .fall(fall)
   );

   pg_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   pg_cycle_ctrl #(.CYC_W(CYC_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .prime(prime),
      .ff_clear(ff_clear), .fall(fall), .cycles_n(cycles_n),
      .start_clr(start_clr), .run(run), .busy(busy), .done(done),
      .ff_q(ff_state)
   );

   pg_total_ctr #(.TOTAL_W(TOTAL_W)) u_total (
      .clk(clk), .rst_n(rst_n), .clr(start_clr), .inc(run && tick),
      .total(total), .ovf(ovf)
   );

   assign cyc_active = run;
endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
   parameter int TW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          gate_en,
   input logic          prime,
   input logic          ff_clear,
   input logic [TW-1:0] total,
   input logic          busy,
   input logic          done,
   input logic          ovf,
   input logic          ff_state,
   input logic          cyc_active
);
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_TOTAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(prime && gate_en)) |=> $stable(total)); // R7
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && total == '1) |=> (total == '1)); // R8
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !(prime && gate_en)) |=> ovf); // R8
   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_en |=> (!busy && !done && !ff_state)); // R9
   AST_ACTIVE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_active |-> busy); // R4
   AST_FF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ff_clear && !prime) |=> !ff_state); // R2
   AST_FF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (ff_state && !cyc_active) |=> !cyc_active); // R3
endmodule

bind period_gauge pg_checker #(.TW(TOTAL_W)) u_pg_chk (
   .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .prime(prime),
   .ff_clear(ff_clear), .total(total), .busy(busy), .done(done),
   .ovf(ovf), .ff_state(ff_state), .cyc_active(cyc_active)
);

// File: tb/tb_period_gauge.sv
module tb_period_gauge;
   localparam int CLK_PERIOD = 10;
   localparam int TW  = 10;
   localparam int CW  = 8;
   localparam int DIV = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          osc_in = 1'b1;
   logic          gate_en = 1'b0;
   logic          prime = 1'b0;
   logic          ff_clear = 1'b0;
   logic [CW-1:0] cycles_n = '0;
   logic [TW-1:0] total;
   logic          busy, done, ovf, ff_state, cyc_active;

   int n_vec  = 0;
   int n_fail = 0;
   int done_seen = 0;
   logic [TW:0] exp_q[$];
   logic [TW-1:0] last_total;

   period_gauge #(.TOTAL_W(TW), .CYC_W(CW), .TICK_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .gate_en(gate_en),
      .prime(prime), .ff_clear(ff_clear), .cycles_n(cycles_n),
      .total(total), .busy(busy), .done(done), .ovf(ovf),
      .ff_state(ff_state), .cyc_active(cyc_active)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int k);
      repeat (k) @(negedge clk);
   endtask

   // monitor: pops the scoreboard on every done pulse
   logic done_prev = 1'b0;
   always @(negedge clk) begin
      if (done_prev) chk("R7 done width", done, 0);
      done_prev <= done;
      if (done) begin
         done_seen++;
         last_total = total;
         if (exp_q.size() == 0) begin
            chk("R7 unexpected done", 1, 0);
         end else begin
            logic [TW:0] e;
            e = exp_q.pop_front();
            chk("R4 total", total, e[TW-1:0]);
            chk("R8 ovf", ovf, e[TW]);
         end
      end
   end

   // driver: one full measurement, expected result pushed to the scoreboard
   task automatic measure(input int n, input int p, input bit junk);
      int ne, raw;
      logic [TW:0] e;
      ne  = (n == 0) ? 1 : n;
      raw = ne * p / DIV;
      e[TW]     = (raw > (1 << TW) - 1);
      e[TW-1:0] = e[TW] ? '1 : TW'(raw);
      gate_en = 1'b1; cycles_n = CW'(n); prime = 1'b1;
      cyc(1);
      prime = 1'b0;
      chk("R2 ff_state set", ff_state, 1);
      chk("R2 busy set", busy, 1);
      chk("R2 total cleared", total, 0);
      if (junk) begin
         for (int j = 0; j < 3; j++) begin
            osc_in = 1'b0; cyc(p/2);
            osc_in = 1'b1; cyc(p/2);
         end
         chk("R3 edges blocked", cyc_active, 0);
      end
      ff_clear = 1'b1;
      cyc(1);
      ff_clear = 1'b0;
      chk("R2 ff_state cleared", ff_state, 0);
      exp_q.push_back(e);
      for (int i = 0; i < ne + 2; i++) begin
         osc_in = 1'b0; cyc(p/2);
         if (i == 0) chk("R4 active after first fall", cyc_active, 1);
         osc_in = 1'b1; cyc(p/2);
      end
      chk("R7 total held after extra edges", total, e[TW-1:0]);
      chk("R7 not busy after stop", busy, 0);
      chk("R4 scoreboard drained", exp_q.size(), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      int ds;
      cyc(3);
      chk("R1 total", total, 0);
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 ovf", ovf, 0);
      chk("R1 ff_state", ff_state, 0);
      chk("R1 cyc_active", cyc_active, 0);
      rst_n = 1'b1;
      cyc(3);

      // R10: prime with gate low
      prime = 1'b1; cyc(1); prime = 1'b0; cyc(1);
      chk("R10 busy", busy, 0);
      chk("R10 ff_state", ff_state, 0);

      // R4 / R5: same total across octave-scaled (N, period) pairs
      measure(1, 64, 0);
      chk("R5 N=1", last_total, 16);
      measure(2, 32, 0);
      chk("R5 N=2", last_total, 16);
      measure(4, 16, 0);
      chk("R5 N=4", last_total, 16);

      // R6: N=0 measured as one cycle
      measure(0, 40, 0);
      chk("R6 N=0", last_total, 10);

      // R8: saturation
      measure(80, 64, 0);
      chk("R8 saturated", last_total, (1 << TW) - 1);
      chk("R8 ovf held", ovf, 1);

      // R3: junk edges while primed, also checks ovf cleared (R2)
      measure(3, 24, 1);
      chk("R3 total", last_total, 18);
      chk("R2 ovf cleared", ovf, 0);

      // R9: abort mid-run
      ds = done_seen;
      gate_en = 1'b1; cycles_n = 8'd10; prime = 1'b1; cyc(1);
      prime = 1'b0; ff_clear = 1'b1; cyc(1); ff_clear = 1'b0;
      for (int i = 0; i < 3; i++) begin
         osc_in = 1'b0; cyc(8);
         osc_in = 1'b1; cyc(8);
      end
      chk("R9 running before abort", cyc_active, 1);
      gate_en = 1'b0; cyc(2);
      chk("R9 busy", busy, 0);
      chk("R9 cyc_active", cyc_active, 0);
      chk("R9 ff_state", ff_state, 0);
      for (int i = 0; i < 10; i++) begin
         osc_in = 1'b0; cyc(8);
         osc_in = 1'b1; cyc(8);
      end
      chk("R9 no done", done_seen, ds);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule